// File: doc/BRIEF.md
# Byte-Wide Host Register Port for a Two-Axis Position Counter

This block is the microprocessor side of a two-axis up/down counter. A host drives an 8-bit bus with an active-low chip select, active-low read and write strobes, a data/control select and an axis select. Every bus input is brought into the system clock domain, and each access takes effect when its strobe returns high. Data-phase writes build a 24-bit preset value for one axis, one byte per access. Data-phase reads return one byte of that axis's 24-bit output latch, which the counter datapath supplies. A per-axis byte pointer picks the byte and moves on by itself after each data access.

Control-phase writes carry their target inside the byte. Bits 6:5 select the command decoder, the count-mode word, the pin-configuration word or the index-configuration word. Bit 7 sends the write to both axes whatever the axis select says. The command decoder is write-only and turns the byte into single-cycle strobes, which ask the counter logic to reset, clear flags or move data in parallel. A control-phase read returns the status byte of the selected axis. The counters, the prescaler and the flag logic sit outside this block.

Top module: `qcnt_host_if`

## Requirements
- R1: After reset all preset bytes, count-mode, pin-configuration and index-configuration words are zero, both byte pointers address byte 0, every strobe output is low, and bus_oe_o and bus_o are zero.
- R2: A write with ctl_i low stores bus_i into the preset of the axis given by axis_i (0 = X = index 0, 1 = Y = index 1), at byte position k = pointer value (bits 8k+7:8k). The other axis's preset does not change.
- R3: Each completed data-phase read or write (ctl_i low) advances that axis's pointer by one, and the pointer wraps from byte 2 to byte 0. A fourth consecutive write therefore lands in byte 0 again.
- R4: During a read with ctl_i low, bus_o shows byte k of the selected axis's latch_i. With ctl_i high it shows that axis's flag_i, and the pointer does not advance.
- R5: bus_oe_o is high only while the synchronized cs_ni and rd_ni are both low. An access with cs_ni high changes no register, no pointer and no strobe.
- R6: A control write with bits 6:5 = 01 loads bits 4:0 into the count-mode word, 10 loads bits 4:0 into the pin-configuration word, and 11 loads bits 2:0 into the index-configuration word. Bit 7 = 0 targets the axis_i axis only. Bit 7 = 1 writes both axes.
- R7: A control write with bits 6:5 = 00 is a command. Bit 0 resets the byte pointer. Bits 2:1 = 01/10/11 pulse ctr_rst_o/flag_clr_o/err_clr_o. Bits 4:3 = 01/10/11 pulse preset_load_o/latch_cap_o/psc_load_o. Each pulse lasts exactly one clock, and bit 7 = 1 applies the command to both axes.
- R8: A write acts only after the rising edge of wr_ni. While wr_ni stays low, nothing changes. The result appears within SYNC_STAGES+2 clocks of the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low; acts on its rising edge |
| ctl_i | input | 1 | 0 = data phase, 1 = control phase |
| axis_i | input | 1 | 0 = X, 1 = Y |
| bus_i | input | DW | Write data from the host |
| bus_o | output | DW | Read data to the host, zero when not driving |
| bus_oe_o | output | 1 | Drive enable for the external tri-state buffer |
| latch_i | input | 2 x DW*NB | Output latch value of each axis |
| flag_i | input | 2 x DW | Status byte of each axis |
| preset_o | output | 2 x DW*NB | Preset value of each axis |
| mode_o | output | 2 x 5 | Count-mode word of each axis |
| ioc_o | output | 2 x 5 | Pin-configuration word of each axis |
| idx_o | output | 2 x 3 | Index-configuration word of each axis |
| ctr_rst_o | output | 2 | Counter reset strobe per axis |
| flag_clr_o | output | 2 | Status-flag clear strobe per axis |
| err_clr_o | output | 2 | Error latch clear strobe per axis |
| preset_load_o | output | 2 | Preset-to-counter transfer strobe per axis |
| latch_cap_o | output | 2 | Counter-to-latch transfer strobe per axis |
| psc_load_o | output | 2 | Preset byte 0 to prescaler strobe per axis |

## Verification
The bench uses the default parameters: DW = 8, NB = 3 and SYNC_STAGES = 2. With three bytes, a fourth write or read returns the pointer to byte 0, so the test can show the wrap together with the fact that flag reads and deselected accesses leave the pointer where it is. The two-stage synchronizer plus the edge-detect stage fixes the delay between a strobe's rising edge and the register update. That fixed delay lets the test hold the write strobe low for a long time, confirm that nothing has moved, and then see the change once the strobe is released.

// File: rtl/qcnt_host_pkg.sv
package qcnt_host_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned AXES   = 2;
  localparam int unsigned MODE_W = 5;
  localparam int unsigned IOC_W  = 5;
  localparam int unsigned IDX_W  = 3;

  // control-byte target field (bits 6:5)
  typedef enum logic [1:0] {
    CSEL_CMD  = 2'b00,
    CSEL_MODE = 2'b01,
    CSEL_IOC  = 2'b10,
    CSEL_IDX  = 2'b11
  } csel_e;

  typedef struct packed {
    logic rst_ptr;
    logic ctr_rst;
    logic flag_clr;
    logic err_clr;
    logic preset_load;
    logic latch_cap;
    logic psc_load;
  } cmd_t;

  function automatic cmd_t cmd_decode(input logic [7:0] b);
    cmd_t c;
    c.rst_ptr     = b[0];
    c.ctr_rst     = (b[2:1] == 2'b01);
    c.flag_clr    = (b[2:1] == 2'b10);
    c.err_clr     = (b[2:1] == 2'b11);
    c.preset_load = (b[4:3] == 2'b01);
    c.latch_cap   = (b[4:3] == 2'b10);
    c.psc_load    = (b[4:3] == 2'b11);
    return c;
  endfunction
endpackage

// File: rtl/qcnt_bus_sync.sv
module qcnt_bus_sync #(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic          ctl_i,
  input  logic          axis_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_done_o,
  output logic          rd_done_o,
  output logic          ev_ctl_o,
  output logic          ev_axis_o,
  output logic [DW-1:0] ev_data_o,
  output logic          rd_act_o,
  output logic          rd_ctl_o,
  output logic          rd_axis_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned W    = DW + 5;
  localparam int unsigned B_CS = DW + 4;
  localparam int unsigned B_RD = DW + 3;
  localparam int unsigned B_WR = DW + 2;
  localparam int unsigned B_CT = DW + 1;
  localparam int unsigned B_AX = DW;
  localparam logic [W-1:0] IDLE = {3'b111, 2'b00, {DW{1'b0}}};

  logic [W-1:0]                  raw;
  logic [W-1:0]                  cur;
  logic [W-1:0]                  prev_q;
  logic [SYNC_STAGES-1:0][W-1:0] stg_q;
  logic [SYNC_STAGES-1:0][W-1:0] stg_d;

  assign raw = {cs_ni, rd_ni, wr_ni, ctl_i, axis_i, data_i};

  always_comb begin
    stg_d[0] = raw;
    for (int i = 1; i < SYNC_STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= {SYNC_STAGES{IDLE}};
      prev_q <= IDLE;
    end else begin
      stg_q  <= stg_d;
      prev_q <= cur;
    end
  end

  assign cur = stg_q[SYNC_STAGES-1];

  // access completes on the low-to-high strobe transition, chip selected
  assign wr_done_o = !prev_q[B_WR] && cur[B_WR] && !prev_q[B_CS];
  assign rd_done_o = !prev_q[B_RD] && cur[B_RD] && !prev_q[B_CS];
  assign ev_ctl_o  = prev_q[B_CT];
  assign ev_axis_o = prev_q[B_AX];
  assign ev_data_o = prev_q[DW-1:0];
  assign rd_act_o  = !cur[B_CS] && !cur[B_RD];
  assign rd_ctl_o  = cur[B_CT];
  assign rd_axis_o = cur[B_AX];
endmodule

// File: rtl/qcnt_ctl_decode.sv
module qcnt_ctl_decode
  import qcnt_host_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            wr_done_i,
  input  logic            rd_done_i,
  input  logic            ev_ctl_i,
  input  logic            ev_axis_i,
  input  logic [DW-1:0]   ev_data_i,
  output logic [AXES-1:0] data_we_o,
  output logic [AXES-1:0] ptr_adv_o,
  output logic [AXES-1:0] mode_we_o,
  output logic [AXES-1:0] ioc_we_o,
  output logic [AXES-1:0] idx_we_o,
  output logic [AXES-1:0] cmd_vld_o,
  output cmd_t            cmd_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned B_ALL = DW - 1;
  localparam int unsigned B_SHI = DW - 2;
  localparam int unsigned B_SLO = DW - 3;

  logic [AXES-1:0] ax_one;
  logic [AXES-1:0] ax_ctl;
  logic            ctl_wr;
  csel_e           sel;

  assign ax_one = ev_axis_i ? 2'b10 : 2'b01;
  assign ax_ctl = ev_data_i[B_ALL] ? {AXES{1'b1}} : ax_one;
  assign sel    = csel_e'(ev_data_i[B_SHI:B_SLO]);
  assign ctl_wr = wr_done_i && ev_ctl_i;

  always_comb begin
    data_we_o = (wr_done_i && !ev_ctl_i) ? ax_one : '0;
    ptr_adv_o = ((wr_done_i || rd_done_i) && !ev_ctl_i) ? ax_one : '0;
    mode_we_o = (ctl_wr && sel == CSEL_MODE) ? ax_ctl : '0;
    ioc_we_o  = (ctl_wr && sel == CSEL_IOC)  ? ax_ctl : '0;
    idx_we_o  = (ctl_wr && sel == CSEL_IDX)  ? ax_ctl : '0;
    cmd_vld_o = (ctl_wr && sel == CSEL_CMD)  ? ax_ctl : '0;
  end

  assign cmd_o = cmd_decode(ev_data_i[7:0]);
endmodule

// File: rtl/qcnt_axis_regs.sv
module qcnt_axis_regs
  import qcnt_host_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned NB = 3,
  localparam int unsigned PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_we_i,
  input  logic              ptr_adv_i,
  input  logic              mode_we_i,
  input  logic              ioc_we_i,
  input  logic              idx_we_i,
  input  logic              cmd_vld_i,
  input  cmd_t              cmd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NB*DW-1:0]  preset_o,
  output logic [PW-1:0]     ptr_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [IOC_W-1:0]  ioc_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              ctr_rst_o,
  output logic              flag_clr_o,
  output logic              err_clr_o,
  output logic              preset_load_o,
  output logic              latch_cap_o,
  output logic              psc_load_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [PW-1:0] LAST = PW'(NB - 1);

  logic [PW-1:0]     ptr_q, ptr_d;
  logic [MODE_W-1:0] mode_q;
  logic [IOC_W-1:0]  ioc_q;
  logic [IDX_W-1:0]  idx_q;
  logic [5:0]        stb_q, stb_d;

  // pointer: command reset wins over advance; wraps after the last byte
  always_comb begin
    ptr_d = ptr_q;
    if (cmd_vld_i && cmd_i.rst_ptr) ptr_d = '0;
    else if (ptr_adv_i)             ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    stb_d = '0;
    if (cmd_vld_i) stb_d = {cmd_i.psc_load, cmd_i.latch_cap, cmd_i.preset_load,
                            cmd_i.err_clr, cmd_i.flag_clr, cmd_i.ctr_rst};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      stb_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      stb_q <= stb_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= wdata_i[MODE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ioc_q <= '0;
    else if (ioc_we_i) ioc_q <= wdata_i[IOC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_we_i) idx_q <= wdata_i[IDX_W-1:0];
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic          hit;
    logic [DW-1:0] byte_q;
    assign hit = data_we_i && (ptr_q == PW'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  byte_q <= '0;
      else if (hit) byte_q <= wdata_i;
    end
    assign preset_o[b*DW +: DW] = byte_q;
  end

  assign ptr_o         = ptr_q;
  assign mode_o        = mode_q;
  assign ioc_o         = ioc_q;
  assign idx_o         = idx_q;
  assign ctr_rst_o     = stb_q[0];
  assign flag_clr_o    = stb_q[1];
  assign err_clr_o     = stb_q[2];
  assign preset_load_o = stb_q[3];
  assign latch_cap_o   = stb_q[4];
  assign psc_load_o    = stb_q[5];
endmodule

// File: rtl/qcnt_host_if.sv
module qcnt_host_if
  import qcnt_host_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned NB          = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cs_ni,
  input  logic                           rd_ni,
  input  logic                           wr_ni,
  input  logic                           ctl_i,
  input  logic                           axis_i,
  input  logic [DW-1:0]                  bus_i,
  output logic [DW-1:0]                  bus_o,
  output logic                           bus_oe_o,
  input  logic [AXES-1:0][NB*DW-1:0]     latch_i,
  input  logic [AXES-1:0][DW-1:0]        flag_i,
  output logic [AXES-1:0][NB*DW-1:0]     preset_o,
  output logic [AXES-1:0][MODE_W-1:0]    mode_o,
  output logic [AXES-1:0][IOC_W-1:0]     ioc_o,
  output logic [AXES-1:0][IDX_W-1:0]     idx_o,
  output logic [AXES-1:0]                ctr_rst_o,
  output logic [AXES-1:0]                flag_clr_o,
  output logic [AXES-1:0]                err_clr_o,
  output logic [AXES-1:0]                preset_load_o,
  output logic [AXES-1:0]                latch_cap_o,
  output logic [AXES-1:0]                psc_load_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned PW = (NB > 1) ? $clog2(NB) : 1;

  logic [1:0]            rst_sync_q;
  logic                  rst_n;
  logic                  wr_done, rd_done, ev_ctl, ev_axis;
  logic [DW-1:0]         ev_data;
  logic                  rd_act, rd_ctl, rd_axis;
  logic [AXES-1:0]       data_we, ptr_adv, mode_we, ioc_we, idx_we, cmd_vld;
  cmd_t                  cmd;
  logic [AXES-1:0][PW-1:0] ptr;
  logic [NB*DW-1:0]      rlatch;
  logic [PW-1:0]         rptr;
  logic [DW-1:0]         rbyte;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  qcnt_bus_sync #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .cs_ni     (cs_ni),
    .rd_ni     (rd_ni),
    .wr_ni     (wr_ni),
    .ctl_i     (ctl_i),
    .axis_i    (axis_i),
    .data_i    (bus_i),
    .wr_done_o (wr_done),
    .rd_done_o (rd_done),
    .ev_ctl_o  (ev_ctl),
    .ev_axis_o (ev_axis),
    .ev_data_o (ev_data),
    .rd_act_o  (rd_act),
    .rd_ctl_o  (rd_ctl),
    .rd_axis_o (rd_axis)
  );

  qcnt_ctl_decode #(.DW(DW)) u_dec (
    .wr_done_i (wr_done),
    .rd_done_i (rd_done),
    .ev_ctl_i  (ev_ctl),
    .ev_axis_i (ev_axis),
    .ev_data_i (ev_data),
    .data_we_o (data_we),
    .ptr_adv_o (ptr_adv),
    .mode_we_o (mode_we),
    .ioc_we_o  (ioc_we),
    .idx_we_o  (idx_we),
    .cmd_vld_o (cmd_vld),
    .cmd_o     (cmd)
  );

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    qcnt_axis_regs #(.DW(DW), .NB(NB)) u_regs (
      .clk_i         (clk_i),
      .rst_ni        (rst_n),
      .data_we_i     (data_we[a]),
      .ptr_adv_i     (ptr_adv[a]),
      .mode_we_i     (mode_we[a]),
      .ioc_we_i      (ioc_we[a]),
      .idx_we_i      (idx_we[a]),
      .cmd_vld_i     (cmd_vld[a]),
      .cmd_i         (cmd),
      .wdata_i       (ev_data),
      .preset_o      (preset_o[a]),
      .ptr_o         (ptr[a]),
      .mode_o        (mode_o[a]),
      .ioc_o         (ioc_o[a]),
      .idx_o         (idx_o[a]),
      .ctr_rst_o     (ctr_rst_o[a]),
      .flag_clr_o    (flag_clr_o[a]),
      .err_clr_o     (err_clr_o[a]),
      .preset_load_o (preset_load_o[a]),
      .latch_cap_o   (latch_cap_o[a]),
      .psc_load_o    (psc_load_o[a])
    );
  end

  // read path: selection follows the synchronized select lines
  always_comb begin
    rlatch = latch_i[rd_axis];
    rptr   = ptr[rd_axis];
    rbyte  = rd_ctl ? flag_i[rd_axis] : DW'(rlatch >> (rptr * DW));
    bus_o  = rd_act ? rbyte : '0;
  end
  assign bus_oe_o = rd_act;
endmodule

// File: rtl/qcnt_host_if_chk.sv
module qcnt_host_if_chk
  import qcnt_host_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned NB          = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        cs_ni,
  input logic                        wr_ni,
  input logic                        bus_oe_o,
  input logic [AXES-1:0][NB*DW-1:0]  preset_o,
  input logic [AXES-1:0][MODE_W-1:0] mode_o,
  input logic [AXES-1:0][IOC_W-1:0]  ioc_o,
  input logic [AXES-1:0][IDX_W-1:0]  idx_o,
  input logic [AXES-1:0]             ctr_rst_o,
  input logic [AXES-1:0]             flag_clr_o,
  input logic [AXES-1:0]             err_clr_o,
  input logic [AXES-1:0]             preset_load_o,
  input logic [AXES-1:0]             latch_cap_o,
  input logic [AXES-1:0]             psc_load_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [3:0] cs_hi_q;
  logic [3:0] wr_hi_q;

  // consecutive samples with the pin high, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_hi_q <= '0;
      wr_hi_q <= '0;
    end else begin
      cs_hi_q <= cs_ni ? ((cs_hi_q == 4'hF) ? cs_hi_q : cs_hi_q + 4'd1) : 4'd0;
      wr_hi_q <= wr_ni ? ((wr_hi_q == 4'hF) ? wr_hi_q : wr_hi_q + 4'd1) : 4'd0;
    end
  end

  p_oe_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_hi_q >= 4'(SYNC_STAGES + 1)) |-> !bus_oe_o);

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_q >= 4'(SYNC_STAGES + 2)) |->
      ($stable(preset_o) && $stable(mode_o) && $stable(ioc_o) && $stable(idx_o)));

  for (genvar a = 0; a < AXES; a++) begin : g_ax
    logic [5:0] stb;
    assign stb = {psc_load_o[a], latch_cap_o[a], preset_load_o[a],
                  err_clr_o[a], flag_clr_o[a], ctr_rst_o[a]};

    p_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|stb) |=> !(|stb));

    p_reset_kind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(stb[2:0]));

    p_xfer_kind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(stb[5:3]));
  end
endmodule

bind qcnt_host_if qcnt_host_if_chk #(.DW(DW), .NB(NB), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_ni         (cs_ni),
  .wr_ni         (wr_ni),
  .bus_oe_o      (bus_oe_o),
  .preset_o      (preset_o),
  .mode_o        (mode_o),
  .ioc_o         (ioc_o),
  .idx_o         (idx_o),
  .ctr_rst_o     (ctr_rst_o),
  .flag_clr_o    (flag_clr_o),
  .err_clr_o     (err_clr_o),
  .preset_load_o (preset_load_o),
  .latch_cap_o   (latch_cap_o),
  .psc_load_o    (psc_load_o)
);

// File: tb/qcnt_host_if_bench.sv
module qcnt_host_if_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_ni, cs_ni, rd_ni, wr_ni, ctl_i, axis_i;
  logic [7:0]       bus_i, bus_o;
  logic             bus_oe_o;
  logic [1:0][23:0] latch_i, preset_o;
  logic [1:0][7:0]  flag_i;
  logic [1:0][4:0]  mode_o, ioc_o;
  logic [1:0][2:0]  idx_o;
  logic [1:0]       ctr_rst_o, flag_clr_o, err_clr_o, preset_load_o, latch_cap_o, psc_load_o;

  int n_chk = 0;
  int n_fail = 0;
  int cnt_stb [6][2];

  always #4 clk = ~clk;

  qcnt_host_if u_qcnt_host_if (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .ctl_i(ctl_i), .axis_i(axis_i), .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .latch_i(latch_i), .flag_i(flag_i), .preset_o(preset_o), .mode_o(mode_o),
    .ioc_o(ioc_o), .idx_o(idx_o), .ctr_rst_o(ctr_rst_o), .flag_clr_o(flag_clr_o),
    .err_clr_o(err_clr_o), .preset_load_o(preset_load_o), .latch_cap_o(latch_cap_o),
    .psc_load_o(psc_load_o)
  );

  // strobe monitor: index 0..5 = ctr_rst, flag_clr, err_clr, preset_load, latch_cap, psc_load
  always @(negedge clk) begin
    for (int a = 0; a < 2; a++) begin
      automatic logic [5:0] s = {psc_load_o[a], latch_cap_o[a], preset_load_o[a],
                                 err_clr_o[a], flag_clr_o[a], ctr_rst_o[a]};
      for (int k = 0; k < 6; k++) if (s[k]) cnt_stb[k][a]++;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_stb();
    @(posedge clk);
    for (int k = 0; k < 6; k++) for (int a = 0; a < 2; a++) cnt_stb[k][a] = 0;
  endtask

  task automatic bus_wr(input logic ctl, input logic ax, input logic [7:0] d, input logic sel_n);
    @(negedge clk);
    cs_ni = sel_n; ctl_i = ctl; axis_i = ax; bus_i = d; wr_ni = 1'b0;
    repeat (4) @(negedge clk);
    wr_ni = 1'b1;
    repeat (4) @(negedge clk);
    cs_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_rd(input logic ctl, input logic ax, input logic sel_n,
                        output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_ni = sel_n; ctl_i = ctl; axis_i = ax; rd_ni = 1'b0;
    repeat (5) @(negedge clk);
    d = bus_o; oe = bus_oe_o;
    rd_ni = 1'b1;
    repeat (4) @(negedge clk);
    cs_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    int sum = 0;
    for (int k = 0; k < 6; k++) for (int a = 0; a < 2; a++) sum += cnt_stb[k][a];
    check("R1", "preset", preset_o, 48'h0);
    check("R1", "mode", mode_o, 0);
    check("R1", "ioc", ioc_o, 0);
    check("R1", "idx", idx_o, 0);
    check("R1", "oe", bus_oe_o, 0);
    check("R1", "bus", bus_o, 0);
    check("R1", "strobes", sum, 0);
  endtask

  task automatic t_preset_x();
    bus_wr(0, 0, 8'h56, 0); bus_wr(0, 0, 8'h34, 0); bus_wr(0, 0, 8'h12, 0);
    check("R2", "preset X", preset_o[0], 24'h123456);
    check("R2", "preset Y untouched", preset_o[1], 24'h0);
  endtask

  task automatic t_wrap();
    bus_wr(0, 0, 8'hAA, 0);
    check("R3", "wrap to byte0", preset_o[0], 24'h1234AA);
  endtask

  task automatic t_preset_y();
    bus_wr(1, 1, 8'h01, 0);
    bus_wr(0, 1, 8'h11, 0); bus_wr(0, 1, 8'h22, 0); bus_wr(0, 1, 8'h33, 0);
    check("R2", "preset Y", preset_o[1], 24'h332211);
    check("R2", "preset X untouched", preset_o[0], 24'h1234AA);
  endtask

  task automatic t_ignore_cs();
    logic [7:0] d; logic oe;
    bus_wr(0, 0, 8'hFF, 1);
    check("R5", "deselected data write", preset_o[0], 24'h1234AA);
    bus_wr(1, 0, 8'h3F, 1);
    check("R5", "deselected control write", mode_o[0], 0);
    bus_rd(0, 0, 1, d, oe);
    check("R5", "oe deselected", oe, 0);
    check("R5", "bus deselected", d, 0);
    bus_wr(0, 0, 8'hBB, 0);
    check("R5", "pointer unmoved", preset_o[0], 24'h12BBAA);
  endtask

  task automatic t_latch_read();
    logic [7:0] d; logic oe;
    bus_wr(1, 0, 8'h01, 0);
    bus_rd(0, 0, 0, d, oe); check("R4", "latch byte0", d, 8'hA1); check("R5", "oe reading", oe, 1);
    bus_rd(0, 0, 0, d, oe); check("R4", "latch byte1", d, 8'hB2);
    bus_rd(0, 0, 0, d, oe); check("R4", "latch byte2", d, 8'hC3);
    bus_rd(0, 0, 0, d, oe); check("R3", "read wrap", d, 8'hA1);
  endtask

  task automatic t_flag_read();
    logic [7:0] d; logic oe;
    bus_rd(1, 1, 0, d, oe); check("R4", "flag Y", d, 8'h5A);
    bus_rd(1, 0, 0, d, oe); check("R4", "flag X", d, 8'h3C);
    bus_rd(0, 1, 0, d, oe); check("R4", "Y ptr after flag read", d, 8'h44);
    bus_rd(0, 0, 0, d, oe); check("R4", "X ptr after flag read", d, 8'hB2);
  endtask

  task automatic t_config();
    bus_wr(1, 0, 8'h3B, 0);
    check("R6", "mode X", mode_o[0], 5'h1B); check("R6", "mode Y", mode_o[1], 0);
    bus_wr(1, 1, 8'h55, 0);
    check("R6", "ioc Y", ioc_o[1], 5'h15); check("R6", "ioc X", ioc_o[0], 0);
    bus_wr(1, 0, 8'h65, 0);
    check("R6", "idx X", idx_o[0], 3'h5); check("R6", "idx Y", idx_o[1], 0);
    bus_wr(1, 0, 8'hA6, 0);
    check("R6", "mode bcast X", mode_o[0], 5'h06); check("R6", "mode bcast Y", mode_o[1], 5'h06);
    bus_wr(1, 1, 8'hE3, 0);
    check("R6", "idx bcast X", idx_o[0], 3'h3); check("R6", "idx bcast Y", idx_o[1], 3'h3);
  endtask

  task automatic t_cmd(input logic [7:0] b, input logic ax);
    logic [1:0] tgt; logic [5:0] ex;
    clear_stb();
    bus_wr(1, ax, b, 0);
    tgt = b[7] ? 2'b11 : (ax ? 2'b10 : 2'b01);
    ex  = {b[4:3] == 2'd3, b[4:3] == 2'd2, b[4:3] == 2'd1,
           b[2:1] == 2'd3, b[2:1] == 2'd2, b[2:1] == 2'd1};
    for (int a = 0; a < 2; a++)
      for (int k = 0; k < 6; k++)
        check("R7", $sformatf("cmd %0h strobe%0d axis%0d", b, k, a),
              cnt_stb[k][a], (tgt[a] && ex[k]) ? 1 : 0);
  endtask

  task automatic t_commands();
    logic [7:0] d; logic oe;
    t_cmd(8'h02, 0); t_cmd(8'h04, 1); t_cmd(8'h06, 0);
    t_cmd(8'h08, 1); t_cmd(8'h10, 0); t_cmd(8'h18, 1);
    t_cmd(8'h92, 0); t_cmd(8'h1E, 1);
    t_cmd(8'h81, 1);
    bus_rd(0, 0, 0, d, oe); check("R7", "bcast ptr reset X", d, 8'hA1);
    bus_rd(0, 1, 0, d, oe); check("R7", "bcast ptr reset Y", d, 8'h44);
  endtask

  task automatic t_wr_edge();
    @(negedge clk);
    cs_ni = 0; ctl_i = 0; axis_i = 0; bus_i = 8'h77; wr_ni = 0;
    repeat (10) @(negedge clk);
    check("R8", "no change while strobe low", preset_o[0], 24'h12BBAA);
    wr_ni = 1;
    repeat (4) @(negedge clk);
    check("R8", "change after rising edge", preset_o[0], 24'h1277AA);
    cs_ni = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < 6; k++) for (int a = 0; a < 2; a++) cnt_stb[k][a] = 0;
    rst_ni = 0; cs_ni = 1; rd_ni = 1; wr_ni = 1; ctl_i = 0; axis_i = 0; bus_i = 8'h00;
    latch_i[0] = 24'hC3B2A1; latch_i[1] = 24'h665544;
    flag_i[0]  = 8'h3C;      flag_i[1]  = 8'h5A;
    repeat (5) @(negedge clk);
    rst_ni = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_preset_x();
    t_wrap();
    t_preset_y();
    t_ignore_cs();
    t_latch_read();
    t_flag_read();
    t_config();
    t_commands();
    t_wr_edge();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule